// File: doc/BRIEF.md
# Two-Channel Converter Input Demultiplexer

This block is the digital front end of a two-channel current-output converter. It takes 14-bit straight offset binary words and delivers them to two DAC-core code registers, each with its own core update strobe and a one-cycle valid pulse. All strobes coming from the data source (write strobes and update clocks) are sampled as levels on one fast fabric clock. Their edges are detected in that domain, so the whole block is a single-clock design.

With the bus-mode input high, the two channels are independent. Each channel has its own data bus, its own write strobe and its own update clock. A write rising edge captures the bus into that channel's input register. An update rising edge moves the input register into the core register. With the bus-mode input low, the block runs in interleaved mode. All words arrive on the A bus under the A write strobe and the A update clock. A select line steers each word into the A or the B input register, and the register that is not selected keeps its word. On the write falling edge the pair of input registers is copied into a hold stage. The shared update clock is halved to form the core clock, and on each rising edge of that core clock both core registers load the held pair.

An align input clears the divider and keeps the core clock low. After align is released, the first core update occurs on the second update-clock rising edge. A source therefore issues one update-clock edge without a write before the first A word. From then on, each core update lands on the edge that carries the next A word. A sleep input freezes both core registers and forces the core strobes low.

Top module: `dacfe_top`

## Requirements
- R1: After synchronous reset, both core codes, both core strobes and both valid pulses are 0. The divider and the hold stage are also cleared.
- R2: In dual mode (mode_dual=1), a rising edge on wr_a (wr_b) captures din_a (din_b) into that channel's input register. A later rising edge on upd_a (upd_b) loads the core register from it. The core code changes one clock after the edge is sampled, and the core strobe follows the update-clock level.
- R3: In dual mode, when the write and update rising edges of a channel fall in the same clock, the core register takes the word captured earlier. The new word waits for the next update edge.
- R4: In dual mode the two channels are independent. Strobes on one channel never change the other channel's core code or valid pulse.
- R5: In interleaved mode (mode_dual=0), a wr_a rising edge writes din_a to the A input register when sel_a=1 and to the B input register when sel_a=0. The other input register keeps its word.
- R6: In interleaved mode, a wr_a falling edge copies both input registers into the hold stage. A core update loads the held pair into both core registers together, so the sequence A0,B0,A1,B1 appears as the pairs (A0,B0) and (A1,B1).
- R7: In interleaved mode, rising edges of upd_a are divided by two to give the core clock. While align=1 the core clock is held low and no update occurs. After align falls, the first core update occurs on the second upd_a rising edge and then on every second one.
- R8: In interleaved mode din_b, wr_b and upd_b have no effect on either core code.
- R9: Codes pass through unchanged over the full 14-bit range, including 0x0000, 0x2000 and 0x3FFF.
- R10: While sleep=1, both core strobes are low, both core registers hold and no valid pulse is issued. Input capture continues, so an update after sleep falls delivers the word written during sleep.
- R11: core_vld_a and core_vld_b pulse high for exactly one clock on each core update of their channel. In interleaved mode the two pulses coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| mode_dual | input | 1 | 1: two independent buses; 0: interleaved on the A bus |
| sleep | input | 1 | Freezes core registers and forces core strobes low |
| align | input | 1 | Clears the divide-by-two and holds the core clock low |
| wr_a | input | 1 | A write strobe (shared write in interleaved mode) |
| upd_a | input | 1 | A update clock (shared clock in interleaved mode) |
| wr_b | input | 1 | B write strobe, dual mode only |
| upd_b | input | 1 | B update clock, dual mode only |
| sel_a | input | 1 | Interleaved steering: 1 to A input register, 0 to B |
| din_a | input | 14 | A data bus, offset binary, bit 13 MSB |
| din_b | input | 14 | B data bus, dual mode only |
| core_a | output | 14 | Code held in the A core register |
| core_b | output | 14 | Code held in the B core register |
| core_clk_a | output | 1 | A core update strobe |
| core_clk_b | output | 1 | B core update strobe |
| core_vld_a | output | 1 | One-clock pulse on each A core update |
| core_vld_b | output | 1 | One-clock pulse on each B core update |

## Verification
The capture of a new word into the input register and its transfer to the core register can fall in the same clock. This happens when a channel's write and update strobes rise together. The bench provokes it by raising both strobes in one step of its vector table. It then expects the core to show the previously captured word, and the new word to appear only at the following update-only step. In interleaved mode, the core update from the divided clock coincides with the capture of the next A word. The bench judges the result by the pair the update delivers.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  parameter int unsigned CODE_W = 14;

  typedef enum logic {
    MODE_IL   = 1'b0,
    MODE_DUAL = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) lvl_q[g] <= 1'b0;
      else     lvl_q[g] <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~lvl_q[g];
    assign fall[g] = ~lvl[g] & lvl_q[g];
  end
endmodule

// File: rtl/dacfe_div.sv
module dacfe_div (
  input  logic clk,
  input  logic rst,
  input  logic align,
  input  logic tick,
  output logic dclk,
  output logic upd
);
  logic armed;

  // first tick after align only arms; later ticks toggle the core clock
  always_ff @(posedge clk) begin
    if (rst || align) begin
      armed <= 1'b0;
      dclk  <= 1'b0;
    end else if (tick) begin
      if (!armed) armed <= 1'b1;
      else        dclk  <= ~dclk;
    end
  end

  assign upd = tick & armed & ~dclk & ~align;
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] din,
  input  logic         ld_hold,
  input  logic         ld_core,
  input  logic         use_hold,
  output logic [W-1:0] core_q
);
  logic [W-1:0] in_r;
  logic [W-1:0] hold_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_r   <= '0;
      hold_r <= '0;
      core_q <= '0;
    end else begin
      if (cap)     in_r   <= din;
      if (ld_hold) hold_r <= in_r;
      if (ld_core) core_q <= use_hold ? hold_r : in_r;
    end
  end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int unsigned DATA_W = CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_dual,
  input  logic              sleep,
  input  logic              align,
  input  logic              wr_a,
  input  logic              upd_a,
  input  logic              wr_b,
  input  logic              upd_b,
  input  logic              sel_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] core_a,
  output logic [DATA_W-1:0] core_b,
  output logic              core_clk_a,
  output logic              core_clk_b,
  output logic              core_vld_a,
  output logic              core_vld_b
);
  localparam int unsigned N_STRB = 4;
  localparam int unsigned N_CH   = 2;

  logic [N_STRB-1:0] strb_lvl, strb_rise, strb_fall;
  assign strb_lvl = {upd_b, wr_b, upd_a, wr_a};

  dacfe_edge #(.N(N_STRB)) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (strb_lvl),
    .rise(strb_rise),
    .fall(strb_fall)
  );

  logic unused_fall;
  assign unused_fall = ^strb_fall[N_STRB-1:1];

  bus_mode_e mode;
  assign mode = mode_dual ? MODE_DUAL : MODE_IL;

  logic dclk, div_upd;
  dacfe_div u_div (
    .clk  (clk),
    .rst  (rst),
    .align(align),
    .tick (strb_rise[1]),
    .dclk (dclk),
    .upd  (div_upd)
  );

  logic [N_CH-1:0]   cap, ld_core;
  logic              ld_hold, use_hold;
  logic [DATA_W-1:0] ch_din  [N_CH];
  logic [DATA_W-1:0] ch_core [N_CH];

  always_comb begin
    if (mode == MODE_DUAL) begin
      cap      = {strb_rise[2], strb_rise[0]};
      ch_din[0] = din_a;
      ch_din[1] = din_b;
      ld_hold  = 1'b0;
      use_hold = 1'b0;
      ld_core  = {strb_rise[3], strb_rise[1]} & {N_CH{~sleep}};
    end else begin
      cap      = {strb_rise[0] & ~sel_a, strb_rise[0] & sel_a};
      ch_din[0] = din_a;
      ch_din[1] = din_a;
      ld_hold  = strb_fall[0];
      use_hold = 1'b1;
      ld_core  = {N_CH{div_upd & ~sleep}};
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dacfe_chan #(.W(DATA_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cap     (cap[g]),
      .din     (ch_din[g]),
      .ld_hold (ld_hold),
      .ld_core (ld_core[g]),
      .use_hold(use_hold),
      .core_q  (ch_core[g])
    );
  end

  assign core_a = ch_core[0];
  assign core_b = ch_core[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      core_vld_a <= 1'b0;
      core_vld_b <= 1'b0;
      core_clk_a <= 1'b0;
      core_clk_b <= 1'b0;
    end else begin
      core_vld_a <= ld_core[0];
      core_vld_b <= ld_core[1];
      core_clk_a <= ~sleep & ((mode == MODE_DUAL) ? upd_a : dclk);
      core_clk_b <= ~sleep & ((mode == MODE_DUAL) ? upd_b : dclk);
    end
  end
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
  parameter int unsigned DATA_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_dual,
  input logic              sleep,
  input logic              align,
  input logic [DATA_W-1:0] core_a,
  input logic [DATA_W-1:0] core_b,
  input logic              core_clk_a,
  input logic              core_clk_b,
  input logic              core_vld_a,
  input logic              core_vld_b
);
  assert_sleep_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (!core_vld_a && !core_vld_b && !core_clk_a && !core_clk_b));

  assert_core_a_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!core_vld_a && !$past(rst)) |-> $stable(core_a));

  assert_core_b_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!core_vld_b && !$past(rst)) |-> $stable(core_b));

  assert_pair_update_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!mode_dual) |-> (core_vld_a == core_vld_b));

  assert_align_low_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(align, 2) && $past(align) && $past(!mode_dual)) |-> (!core_clk_a && !core_clk_b));

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    core_vld_a |=> !core_vld_a);
endmodule

bind dacfe_top dacfe_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_dual (mode_dual),
  .sleep     (sleep),
  .align     (align),
  .core_a    (core_a),
  .core_b    (core_b),
  .core_clk_a(core_clk_a),
  .core_clk_b(core_clk_b),
  .core_vld_a(core_vld_a),
  .core_vld_b(core_vld_b)
);

// File: tb/tb_dacfe_top.sv
module tb_dacfe_top;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst, mode_dual, sleep, align, wr_a, upd_a, wr_b, upd_b, sel_a;
  logic [W-1:0] din_a, din_b, core_a, core_b;
  logic core_clk_a, core_clk_b, core_vld_a, core_vld_b;

  always #4 clk = ~clk;

  dacfe_top #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .mode_dual(mode_dual), .sleep(sleep), .align(align),
    .wr_a(wr_a), .upd_a(upd_a), .wr_b(wr_b), .upd_b(upd_b), .sel_a(sel_a),
    .din_a(din_a), .din_b(din_b), .core_a(core_a), .core_b(core_b),
    .core_clk_a(core_clk_a), .core_clk_b(core_clk_b),
    .core_vld_a(core_vld_a), .core_vld_b(core_vld_b)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic s_vld_a, s_vld_b, s_clk_a;

  // {wr, upd, din[13:0], expected core_a[13:0]} for dual-mode channel A
  localparam logic [29:0] VEC [9] = '{
    {1'b1, 1'b0, 14'h1234, 14'h0000},
    {1'b0, 1'b1, 14'h0000, 14'h1234},
    {1'b1, 1'b1, 14'h3FFF, 14'h1234},
    {1'b0, 1'b1, 14'h0000, 14'h3FFF},
    {1'b1, 1'b0, 14'h0000, 14'h3FFF},
    {1'b1, 1'b0, 14'h2000, 14'h3FFF},
    {1'b0, 1'b1, 14'h0000, 14'h2000},
    {1'b1, 1'b1, 14'h0001, 14'h2000},
    {1'b0, 1'b1, 14'h0000, 14'h0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic wa, input logic ua, input logic wb, input logic ub,
                        input logic [W-1:0] da, input logic [W-1:0] db, input logic s);
    @(negedge clk);
    wr_a = wa; upd_a = ua; wr_b = wb; upd_b = ub; din_a = da; din_b = db; sel_a = s;
    @(negedge clk);
    s_vld_a = core_vld_a; s_vld_b = core_vld_b; s_clk_a = core_clk_a;
    wr_a = 1'b0; upd_a = 1'b0; wr_b = 1'b0; upd_b = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_dual = 1'b1; sleep = 1'b0; align = 1'b0;
    wr_a = 1'b0; upd_a = 1'b0; wr_b = 1'b0; upd_b = 1'b0; sel_a = 1'b0;
    din_a = '0; din_b = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 core_a", core_a, 0);
    chk("R1 core_b", core_b, 0);
    chk("R1 strobes/valid", {core_clk_a, core_clk_b, core_vld_a, core_vld_b}, 0);

    // dual-mode vector table for channel A (R2, R3, R9)
    foreach (VEC[i]) begin
      strobe(VEC[i][29], VEC[i][28], 1'b0, 1'b0, VEC[i][27:14], 14'h0, 1'b0);
      if (VEC[i][29] && VEC[i][28]) chk("R3 same-cycle core_a", core_a, VEC[i][13:0]);
      else                          chk("R2 R9 core_a", core_a, VEC[i][13:0]);
      chk("R11 vld_a", s_vld_a, VEC[i][28]);
      if (VEC[i][28]) chk("R2 core_clk_a", s_clk_a, 1);
      chk("R4 core_b untouched", core_b, 0);
    end

    // channel B alone (R4)
    strobe(1'b0, 1'b0, 1'b1, 1'b0, 14'h2222, 14'h0155, 1'b0);
    strobe(1'b0, 1'b0, 1'b0, 1'b1, 14'h0000, 14'h0000, 1'b0);
    chk("R4 core_b", core_b, 14'h0155);
    chk("R4 core_a unchanged", core_a, 14'h0001);
    chk("R4 vld pair", {s_vld_a, s_vld_b}, 2'b01);

    // sleep (R10)
    sleep = 1'b1;
    strobe(1'b1, 1'b0, 1'b0, 1'b0, 14'h0AAA, 14'h0, 1'b0);
    strobe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 14'h0, 1'b0);
    chk("R10 core_a frozen", core_a, 14'h0001);
    chk("R10 no vld/strobe", {s_vld_a, s_clk_a}, 0);
    sleep = 1'b0;
    strobe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 14'h0, 1'b0);
    chk("R10 capture during sleep", core_a, 14'h0AAA);
    chk("R10 awake vld/strobe", {s_vld_a, s_clk_a}, 2'b11);

    // interleaved mode (R5..R8)
    @(negedge clk);
    mode_dual = 1'b0; align = 1'b1;
    strobe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0, 14'h3333, 1'b1);
    strobe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0, 14'h3333, 1'b1);
    chk("R7 align holds core clock low", s_clk_a, 0);
    chk("R7 no update under align", {s_vld_a, s_vld_b}, 0);
    align = 1'b0;
    strobe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0, 14'h3333, 1'b1);
    chk("R7 first edge no update", {s_vld_a, s_vld_b}, 0);
    strobe(1'b1, 1'b1, 1'b1, 1'b1, 14'h0ABC, 14'h3333, 1'b1);
    chk("R7 second edge updates", {s_vld_a, s_vld_b}, 2'b11);
    strobe(1'b1, 1'b1, 1'b1, 1'b1, 14'h1DEF, 14'h3333, 1'b0);
    chk("R7 odd edge idle", {s_vld_a, s_vld_b}, 0);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h2345, 14'h3333, 1'b1);
    chk("R6 pair0 core_a", core_a, 14'h0ABC);
    chk("R6 R8 pair0 core_b", core_b, 14'h1DEF);
    chk("R11 paired vld", {s_vld_a, s_vld_b}, 2'b11);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h3FFF, 14'h3333, 1'b0);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h0000, 14'h3333, 1'b1);
    chk("R6 pair1 core_a", core_a, 14'h2345);
    chk("R6 R9 pair1 core_b", core_b, 14'h3FFF);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h0202, 14'h3333, 1'b0);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h0303, 14'h3333, 1'b1);
    chk("R6 pair2 core_b", core_b, 14'h0202);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h0404, 14'h3333, 1'b1);
    strobe(1'b1, 1'b1, 1'b0, 1'b0, 14'h0505, 14'h3333, 1'b1);
    chk("R5 A overwritten", core_a, 14'h0404);
    chk("R5 R8 B retained", core_b, 14'h0202);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule